// File: doc/BRIEF.md
# Touch-Screen ADC Serial Command and Conversion Sequencer

This block is the serial slave engine of a resistive touch-screen converter. It runs from the serial clock. While chip select is high, the whole engine is held in reset. Once select is low, the block watches the data input for a start bit. It then takes in a seven-bit command, opens an acquisition window, and runs a successive-approximation search. The search uses a comparator bit that the analog front end returns. Each decided bit leaves on the serial output as soon as it is known, most significant bit first. A busy flag marks the single clock between the command and the first result bit.

The command sets four things: the input channel, a 12-bit or 8-bit resolution, single-ended or ratiometric referencing, and a power mode. These fields are latched for the switch controller, alongside the acquisition and conversion phase strobes and the trial DAC code. A new command may begin while the previous result is still shifting out. This supports frames of 24, 16, 15 (12-bit) or 11 (8-bit) clocks per conversion.

Top module: `tsc_serial_seq`

In the requirements below, the rising edge that samples the start bit is called edge 0. Later rising edges are numbered from it.

## Requirements
- R1: While no frame is open, a low `din` at a rising edge is ignored. The first high `din` is taken as the start bit.
- R2: After the start bit, the next seven rising edges sample, in order: channel bits 2..0 (MSB first), the resolution select (0 = 12 bits, 1 = 8 bits), the reference select (1 = single-ended), and power bits 1..0. These fields appear on `cfg_chan`, `cfg_short`, `cfg_ref_se` and `cfg_pd` right after edge 7.
- R3: `acq_on` is high for exactly three clocks, from just after edge 3 (the last channel bit) until edge 6.
- R4: `busy` rises on the falling edge after edge 7 and falls on the next falling edge. It is high for exactly one clock and changes only on falling edges.
- R5: During conversion, `dac_code` holds the bits decided so far plus a single trial bit, with all lower bits zero. A comparator value of 1 sampled at the next rising edge keeps the trial bit, and 0 clears it.
- R6: The result goes out straight binary, MSB first, one bit per falling edge, starting at the falling edge after edge 8. It is 12 bits long in 12-bit mode and 8 bits in 8-bit mode. `dout` is 0 at all other times.
- R7: A new start bit is accepted at edge 15 or later after a 12-bit command, or at edge 11 or later after an 8-bit command. A high `din` before that is not a start.
- R8: With `cs_n` high, `out_en`, `busy` and `dout` are low. A conversion in progress is dropped, and after reselect no result bit appears until a new command arrives.
- R9: `conv_on` is high for exactly 12 (12-bit) or 8 (8-bit) clocks, starting just after edge 7. One result bit is decided at each rising edge in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low; high acts as asynchronous reset |
| din | input | 1 | Serial command input, sampled on rising edges |
| comp | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| dout | output | 1 | Serial result, updated on falling edges |
| busy | output | 1 | Conversion-start flag, updated on falling edges |
| out_en | output | 1 | Drive enable for the `dout` and `busy` pads |
| acq_on | output | 1 | Acquisition phase strobe |
| conv_on | output | 1 | Conversion phase strobe |
| dac_code | output | FULL_BITS | Trial code for the capacitive DAC |
| cfg_chan | output | 3 | Latched channel select |
| cfg_short | output | 1 | Latched resolution select (1 = 8 bits) |
| cfg_ref_se | output | 1 | Latched reference select (1 = single-ended) |
| cfg_pd | output | 2 | Latched power mode |

## Verification
The bench builds the block with its default parameters: 12 and 8 result bits and a three-clock acquisition window. With these values, both reopen distances (15 and 11 edges) fall within short runs, and each comparator-driven search can be checked bit by bit against an analog value chosen by the bench. The bench exercises back-to-back frames of 24, 16, 15 and 11 clocks, a stray high bit inside the holdoff window, and a select release in the middle of a conversion.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CTRL_BITS = 8;  // start bit plus seven command bits
  localparam int CHAN_END  = 3;  // edge index that samples the last channel bit

  typedef struct packed {
    logic [2:0] chan;
    logic       short_res;
    logic       ref_se;
    logic [1:0] pd;
  } cmd_t;

  // earliest edge, counted from the previous start bit, that may carry a new start bit
  function automatic int reopen_edge(input int res_bits);
    return res_bits + CHAN_END;
  endfunction
endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx import tsc_pkg::*; #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic launch,
  output logic launch_short,
  output logic acq_on,
  output logic busy_next,
  output cmd_t cfg
);
  localparam int CNT_W = $clog2(FULL_BITS + CTRL_BITS + 8);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CTRL_BITS - 2);
  localparam logic [CNT_W-1:0] BUSY_AT   = CNT_W'(CTRL_BITS - 1);
  localparam logic [CNT_W-1:0] ACQ_FROM  = CNT_W'(CHAN_END);
  localparam logic [CNT_W-1:0] ACQ_TO    = CNT_W'(CHAN_END + ACQ_CYCLES);
  localparam logic [CNT_W-1:0] THR_FULL  = CNT_W'(reopen_edge(FULL_BITS) - 1);
  localparam logic [CNT_W-1:0] THR_SHORT = CNT_W'(reopen_edge(SHORT_BITS) - 1);

  logic             in_frame;
  logic [CNT_W-1:0] cnt;
  logic [5:0]       sr;
  logic             accept;
  logic             start_seen;
  cmd_t             launch_cmd;

  assign accept       = !in_frame || (cnt >= (cfg.short_res ? THR_SHORT : THR_FULL));
  assign start_seen   = accept && din;
  assign launch       = in_frame && (cnt == LAST_CTRL);
  assign launch_cmd   = cmd_t'({sr, din});
  assign launch_short = launch_cmd.short_res;
  assign acq_on       = in_frame && (cnt >= ACQ_FROM) && (cnt < ACQ_TO);
  assign busy_next    = in_frame && (cnt == BUSY_AT);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      cfg      <= '0;
    end else if (start_seen) begin
      in_frame <= 1'b1;
      cnt      <= '0;
    end else if (in_frame) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt < LAST_CTRL) sr <= {sr[4:0], din};
      if (launch) cfg <= launch_cmd;
    end
  end

  // R1: a low input with no open frame leaves the receiver idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && !din) |=> !in_frame);

  // R7: inside the holdoff the frame counter only advances
  a_r7_holdoff: assert property (@(posedge clk) disable iff (rst)
    (in_frame && cnt < THR_SHORT) |=> (cnt == $past(cnt) + 1'b1));

  // R3: the acquisition strobe never lasts a single clock
  a_r3_acq_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_on) |=> acq_on);
endmodule

// File: rtl/tsc_sar_core.sv
module tsc_sar_core #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch,
  input  logic                 short_res,
  input  logic                 comp,
  output logic [FULL_BITS-1:0] dac_code,
  output logic                 converting,
  output logic                 bit_strobe,
  output logic                 bit_value
);
  localparam int POS_W = $clog2(FULL_BITS);
  localparam logic [FULL_BITS-1:0] ONE = {{(FULL_BITS-1){1'b0}}, 1'b1};

  logic [FULL_BITS-1:0] sar;
  logic [POS_W-1:0]     pos;
  logic [POS_W-1:0]     left;
  logic                 running;
  logic                 last_bit;

  // resolve the current trial bit and, unless finished, place the next trial
  function automatic logic [FULL_BITS-1:0] settle(input logic [FULL_BITS-1:0] code,
                                                  input logic [POS_W-1:0] p,
                                                  input logic keep, input logic fin);
    logic [FULL_BITS-1:0] c;
    c    = code;
    c[p] = keep;
    if (!fin) c[p - 1'b1] = 1'b1;
    return c;
  endfunction

  function automatic logic [FULL_BITS-1:0] below(input logic [POS_W-1:0] p);
    return (ONE << p) - ONE;
  endfunction

  assign last_bit   = (left == '0);
  assign dac_code   = sar;
  assign converting = running;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sar        <= '0;
      pos        <= '0;
      left       <= '0;
      running    <= 1'b0;
      bit_strobe <= 1'b0;
      bit_value  <= 1'b0;
    end else begin
      bit_strobe <= 1'b0;
      if (launch) begin
        running <= 1'b1;
        sar     <= ONE << (FULL_BITS - 1);
        pos     <= POS_W'(FULL_BITS - 1);
        left    <= POS_W'((short_res ? SHORT_BITS : FULL_BITS) - 1);
      end else if (running) begin
        bit_strobe <= 1'b1;
        bit_value  <= comp;
        sar        <= settle(sar, pos, comp, last_bit);
        if (last_bit) begin
          running <= 1'b0;
        end else begin
          pos  <= pos - 1'b1;
          left <= left - 1'b1;
        end
      end
    end
  end

  // R5: bits below the trial position stay clear while searching
  a_r5_below_clear: assert property (@(posedge clk) disable iff (rst)
    running |-> ((sar & below(pos)) == '0));

  // R9: every clock of the search yields one decided bit
  a_r9_one_decision: assert property (@(posedge clk) disable iff (rst)
    running |=> bit_strobe);

  // R9: a command never completes while a search is still running
  a_r9_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    launch |-> !running);
endmodule

// File: rtl/tsc_out_stage.sv
module tsc_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic busy_next,
  input  logic bit_strobe,
  input  logic bit_value,
  output logic busy,
  output logic dout
);
  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      busy <= 1'b0;
      dout <= 1'b0;
    end else begin
      busy <= busy_next;
      dout <= bit_strobe & bit_value;
    end
  end

  // R4: busy covers one clock only
  a_r4_busy_single: assert property (@(negedge clk) disable iff (rst)
    busy |=> !busy);
endmodule

// File: rtl/tsc_serial_seq.sv
module tsc_serial_seq import tsc_pkg::*; #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 3
) (
  input  logic                 dclk,
  input  logic                 cs_n,
  input  logic                 din,
  input  logic                 comp,
  output logic                 dout,
  output logic                 busy,
  output logic                 out_en,
  output logic                 acq_on,
  output logic                 conv_on,
  output logic [FULL_BITS-1:0] dac_code,
  output logic [2:0]           cfg_chan,
  output logic                 cfg_short,
  output logic                 cfg_ref_se,
  output logic [1:0]           cfg_pd
);
  logic launch;
  logic launch_short;
  logic busy_next;
  logic bit_strobe;
  logic bit_value;
  cmd_t cfg;

  tsc_cmd_rx #(.FULL_BITS(FULL_BITS), .SHORT_BITS(SHORT_BITS), .ACQ_CYCLES(ACQ_CYCLES)) u_rx (
    .clk(dclk), .rst(cs_n), .din(din),
    .launch(launch), .launch_short(launch_short),
    .acq_on(acq_on), .busy_next(busy_next), .cfg(cfg)
  );

  tsc_sar_core #(.FULL_BITS(FULL_BITS), .SHORT_BITS(SHORT_BITS)) u_sar (
    .clk(dclk), .rst(cs_n), .launch(launch), .short_res(launch_short), .comp(comp),
    .dac_code(dac_code), .converting(conv_on),
    .bit_strobe(bit_strobe), .bit_value(bit_value)
  );

  tsc_out_stage u_out (
    .clk(dclk), .rst(cs_n), .busy_next(busy_next),
    .bit_strobe(bit_strobe), .bit_value(bit_value),
    .busy(busy), .dout(dout)
  );

  assign out_en     = ~cs_n;
  assign cfg_chan   = cfg.chan;
  assign cfg_short  = cfg.short_res;
  assign cfg_ref_se = cfg.ref_se;
  assign cfg_pd     = cfg.pd;
endmodule

// File: tb/tsc_serial_seq_test.sv
module tsc_serial_seq_test;
  localparam int FB   = 12;
  localparam int SB   = 8;
  localparam int NCYC = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          cs_n = 1'b1;
  logic          din  = 1'b0;
  logic [FB-1:0] vin_cur = '0;
  logic          dout, busy, out_en, acq_on, conv_on, cfg_short, cfg_ref_se;
  logic [FB-1:0] dac_code;
  logic [2:0]    cfg_chan;
  logic [1:0]    cfg_pd;
  wire           comp = (vin_cur >= dac_code);

  tsc_serial_seq uut (
    .dclk(clk), .cs_n(cs_n), .din(din), .comp(comp),
    .dout(dout), .busy(busy), .out_en(out_en), .acq_on(acq_on), .conv_on(conv_on),
    .dac_code(dac_code), .cfg_chan(cfg_chan), .cfg_short(cfg_short),
    .cfg_ref_se(cfg_ref_se), .cfg_pd(cfg_pd)
  );

  int drive_q[$];
  int vin_q[$];
  int tests = 0, fails = 0;
  int cyc = 0, ls = -1, lmode = 0, ctrl = 0, cfg_at = -1, exp_cfg = 0;
  bit eb[NCYC], ed[NCYC], ea[NCYC], ec[NCYC];
  int edac[NCYC];
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int csv, input int n, input int d);
    for (int i = 0; i < n; i++) drive_q.push_back((csv << 1) | d);
  endtask

  task automatic frame(input int chan, input int mode, input int se, input int pd,
                       input int v, input int len);
    int word;
    word = (1 << 7) | (chan << 4) | (mode << 3) | (se << 2) | pd;
    for (int i = 7; i >= 0; i--) push(0, 1, (word >> i) & 1);
    push(0, len - 8, 0);
    vin_q.push_back(v);
  endtask

  // input driver: one entry per falling edge
  always @(negedge clk) begin
    int e;
    if (drive_q.size() > 0) begin
      e = drive_q.pop_front();
      cs_n = e[1];
      din  = e[0];
    end else begin
      din = 1'b0;
    end
  end

  // behavioural reference: decides expected outputs per rising-edge index
  always @(posedge clk) begin
    int since, thr, e, nb, res, v;
    cyc = cyc + 1;
    if (cyc < NCYC - 64) begin
      if (cs_n) begin
        ls = -1;
        for (int i = cyc; i < cyc + 48; i++) begin
          eb[i] = 0; ed[i] = 0; ea[i] = 0; ec[i] = 0;
        end
      end else begin
        since = (ls < 0) ? 1000 : cyc - ls;
        thr   = (lmode != 0 ? SB : FB) + 3;
        if (since >= thr && din) begin
          ls = cyc;
          ctrl = 0;
        end else if (ls >= 0) begin
          e = cyc - ls;
          if (e >= 1 && e <= 7) ctrl = (ctrl << 1) | int'(din);
          if (e == 4) lmode = int'(din);
          if (e >= 3 && e <= 5) ea[cyc] = 1;
          if (e == 7) begin
            v       = vin_q.pop_front();
            vin_cur = FB'(v);
            nb      = (lmode != 0) ? SB : FB;
            res     = (lmode != 0) ? (v >> (FB - SB)) : v;
            eb[cyc] = 1;
            cfg_at  = cyc;
            exp_cfg = ctrl;
            for (int k = 0; k < nb; k++) begin
              ed[cyc + 1 + k] = ((res >> (nb - 1 - k)) & 1) != 0;
              ec[cyc + k]     = 1;
              edac[cyc + k]   = (v & ~((1 << (FB - k)) - 1) & ((1 << FB) - 1)) | (1 << (FB - 1 - k));
            end
          end
        end
      end
    end
  end

  // comparison, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (!done && cyc > 0 && cyc < NCYC - 64) begin
      if (cs_n) begin
        chk("R8 out_en", out_en, 0);
        chk("R8 busy", busy, 0);
        chk("R8 dout", dout, 0);
      end else begin
        chk("R8 out_en", out_en, 1);
        chk("R4 R1 R7 busy", busy, eb[cyc]);
        chk("R6 R8 dout", dout, ed[cyc]);
        chk("R3 acq_on", acq_on, ea[cyc]);
        chk("R9 conv_on", conv_on, ec[cyc]);
        if (ec[cyc]) chk("R5 dac_code", dac_code, edac[cyc]);
        if (cfg_at == cyc)
          chk("R2 cfg", {cfg_chan, cfg_short, cfg_ref_se, cfg_pd}, exp_cfg);
      end
    end
  end

  initial begin
    push(1, 4, 0);                       // R8: deselected reset state
    push(0, 3, 0);                       // R1: idle zeros
    frame(3'b001, 0, 1, 2'b00, 12'hA5C, 24);
    frame(3'b110, 1, 0, 2'b11, 12'h3F7, 24);
    frame(3'b101, 0, 0, 2'b01, 12'hFFF, 15);   // R7: 15-clock overlap
    frame(3'b011, 0, 1, 2'b10, 12'h000, 15);
    frame(3'b100, 0, 0, 2'b11, 12'h801, 24);
    frame(3'b010, 1, 1, 2'b00, 12'h7FF, 11);   // R7: 11-clock overlap
    frame(3'b111, 1, 0, 2'b01, 12'h123, 11);
    frame(3'b000, 1, 1, 2'b10, 12'hF0F, 24);
    frame(3'b001, 0, 0, 2'b11, 12'h5A5, 16);
    frame(3'b110, 0, 1, 2'b00, 12'h3C3, 12);   // R7: stray high bit in holdoff
    push(0, 1, 1);
    push(0, 6, 0);
    frame(3'b101, 0, 1, 2'b01, 12'h9E4, 12);   // R8: abort mid-conversion
    push(1, 3, 0);
    push(0, 4, 0);
    frame(3'b011, 1, 0, 2'b10, 12'hC81, 24);
    wait (drive_q.size() == 0);
    repeat (30) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule